// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. It has no clock. It takes a 4-bit operation code, a first operand, and a second operand that an upstream barrel shifter has already rotated or shifted. From these it produces:

- the operation result;
- a write strobe for the destination register;
- the next program status word;
- a request to restore the saved status word into the current one.

The next status word has the negative, zero, carry and overflow flags in bits 31, 30, 29 and 28. Bits 27:0 are always copied from the current status word.

The surrounding pipeline supplies further inputs:

- the shifter's carry-out;
- the current carry flag;
- the "set flags" bit from the instruction;
- a marker that says the destination is the program counter;
- the current and saved status words.

The pipeline writes `result_o` into the register file when `rd_we_o` is high. It writes `psr_next_o` back into the current status register. The register file, the shifter and instruction decode all sit outside this block.

Four classes of operation are handled:

- **Bitwise:** AND, EOR, ORR, MOV, BIC and MVN.
- **Subtract:** SUB and RSB. A set carry means "no borrow".
- **Add:** ADD and ADC.
- **Compare:** TST, TEQ, CMP and CMN. These only update flags.

SBC and RSC take the subtrahend as operand plus one minus carry, computed wider than 32 bits. This keeps the carry correct when that sum wraps.

Top module: `dp_alu`

## Requirements
- R1: `op_i` selects the operation as follows: 0 AND (a&b), 1 EOR (a^b), 2 SUB (a-b), 3 RSB (b-a), 4 ADD (a+b), 5 ADC (a+b+carry), 6 SBC (a-b-!carry), 7 RSC (b-a-!carry), 8 TST (a&b), 9 TEQ (a^b), 10 CMP (a-b), 11 CMN (a+b), 12 ORR (a|b), 13 MOV (b), 14 BIC (a&~b), 15 MVN (~b). `result_o` carries that value for every code, taken modulo 2^32.
- R2: When flags update, the bitwise operations and TST and TEQ set the flags as follows: N = result bit 31, Z = (result == 0), C = `shift_c_i`, and V is kept from `cpsr_i` bit 28.
- R3: For SUB, CMP and RSB, C is set when the subtrahend is unsigned less than or equal to the minuend (no borrow). V is set on signed overflow of the subtraction.
- R4: For ADD and CMN, C is the unsigned carry out of bit 31. V is set on signed overflow of the addition.
- R5: For ADC, C is set when a + b + carry exceeds 2^32-1, including the case where only the carry-in causes the wrap. V is signed overflow of the same sum.
- R6: For SBC and RSC, C is set when the subtrahend plus 1 minus carry, evaluated without wrap, is less than or equal to the minuend. With subtrahend 0xFFFFFFFF and carry clear, this gives C = 0. V is signed overflow of the full difference.
- R7: Codes 8 to 11 never assert `rd_we_o`. They update the flags even when `set_flags_i` is low. All other codes assert `rd_we_o`.
- R8: When `set_flags_i` is low and the code is not 8 to 11, `psr_next_o` equals `cpsr_i` and `restore_o` is low.
- R9: When `set_flags_i` is high, `dst_pc_i` is high and the code is not 8 to 11, the following hold: `restore_o` is high, `psr_next_o` equals `spsr_i`, and `rd_we_o` stays high.
- R10: When the code is 8 to 11 and `dst_pc_i` is high, `restore_o` is high and `psr_next_o` equals `spsr_i`, whatever the value of `set_flags_i`.
- R11: When `restore_o` is low, bits 27:0 of `psr_next_o` equal those of `cpsr_i`. When flags update, bits 31, 30, 29 and 28 hold N, Z, C and V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, already shifted |
| shift_c_i | input | 1 | Carry-out from the shifter |
| carry_i | input | 1 | Current carry flag, used by ADC, SBC and RSC |
| set_flags_i | input | 1 | The instruction requests a flag update |
| dst_pc_i | input | 1 | The destination field names the program counter |
| cpsr_i | input | 32 | Current status word |
| spsr_i | input | 32 | Saved status word |
| result_o | output | 32 | Operation result |
| rd_we_o | output | 1 | Destination register write strobe |
| psr_next_o | output | 32 | Next value of the status word |
| restore_o | output | 1 | The saved status word replaces the current one |

## Verification
The block holds no state. A fault in its class decode or its carry logic therefore shows at the ports as soon as the inputs settle, within the same cycle. A wrongly decoded compare code shows as a spurious `rd_we_o`. A wrong borrow convention flips bit 29 of `psr_next_o` on any subtraction with equal operands. A narrow SBC subtrahend shows as C set when the second operand is all ones and the carry is clear. A missed restore shows as `psr_next_o` differing from `spsr_i` when the destination is the program counter.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0,
        OP_EOR = 4'h1,
        OP_SUB = 4'h2,
        OP_RSB = 4'h3,
        OP_ADD = 4'h4,
        OP_ADC = 4'h5,
        OP_SBC = 4'h6,
        OP_RSC = 4'h7,
        OP_TST = 4'h8,
        OP_TEQ = 4'h9,
        OP_CMP = 4'hA,
        OP_CMN = 4'hB,
        OP_ORR = 4'hC,
        OP_MOV = 4'hD,
        OP_BIC = 4'hE,
        OP_MVN = 4'hF
    } alu_op_e;

    // Flag positions within the status word; the pipeline decodes these.
    localparam int unsigned PSR_N_BIT = 31;
    localparam int unsigned PSR_Z_BIT = 30;
    localparam int unsigned PSR_C_BIT = 29;
    localparam int unsigned PSR_V_BIT = 28;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic op_is_compare(input alu_op_e op);
        return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

    function automatic logic op_is_bitwise(input alu_op_e op);
        return (op == OP_AND) || (op == OP_EOR) || (op == OP_TST) || (op == OP_TEQ) ||
               (op == OP_ORR) || (op == OP_MOV) || (op == OP_BIC) || (op == OP_MVN);
    endfunction

endpackage

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
    import dp_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [WIDTH-1:0]   res
);

    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end

endmodule

// File: rtl/dp_arith_unit.sv
module dp_arith_unit
    import dp_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic               cin,
    output logic [WIDTH-1:0]   res,
    output logic               c_out,
    output logic               v_out
);

    localparam int unsigned MSB  = WIDTH - 1;
    localparam int unsigned WIDE = WIDTH + 2;

    logic             is_sub;
    logic             swap;
    logic             use_cin;
    logic [WIDTH-1:0] x;
    logic [WIDTH-1:0] y;
    logic [WIDE-1:0]  subtr;
    logic [WIDE-1:0]  diff;
    logic [WIDTH:0]   sum;

    always_comb begin
        is_sub  = 1'b0;
        swap    = 1'b0;
        use_cin = 1'b0;
        unique case (op)
            OP_SUB, OP_CMP: is_sub = 1'b1;
            OP_RSB:         begin is_sub = 1'b1; swap = 1'b1; end
            OP_SBC:         begin is_sub = 1'b1; use_cin = 1'b1; end
            OP_RSC:         begin is_sub = 1'b1; swap = 1'b1; use_cin = 1'b1; end
            OP_ADC:         use_cin = 1'b1;
            default:        ;
        endcase
    end

    assign x = swap ? b : a;
    assign y = swap ? a : b;

    // The subtrahend is y + !cin for the carry forms and is kept two bits wider than the data, so y = all ones with cin = 0 does not wrap.
    assign subtr = {2'b00, y} + {{(WIDE-1){1'b0}}, use_cin & ~cin};
    assign diff  = {2'b00, x} - subtr;
    assign sum   = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, use_cin & cin};

    always_comb begin
        if (is_sub) begin
            res   = diff[WIDTH-1:0];
            c_out = (subtr <= {2'b00, x});
            v_out = ((x[MSB] ^ res[MSB]) & (~y[MSB] ^ res[MSB]));
        end else begin
            res   = sum[WIDTH-1:0];
            c_out = sum[WIDTH];
            v_out = ((x[MSB] ^ res[MSB]) & (y[MSB] ^ res[MSB]));
        end
    end

endmodule

// File: rtl/dp_flag_mux.sv
module dp_flag_mux
    import dp_alu_pkg::*;
#(
    parameter int unsigned PSR_W = 32
) (
    input  logic              update,
    input  logic              restore,
    input  nzcv_t             flags,
    input  logic [PSR_W-1:0]  cpsr,
    input  logic [PSR_W-1:0]  spsr,
    output logic [PSR_W-1:0]  psr_next
);

    always_comb begin
        psr_next = cpsr;
        if (restore) begin
            psr_next = spsr;
        end else if (update) begin
            psr_next[PSR_N_BIT] = flags.n;
            psr_next[PSR_Z_BIT] = flags.z;
            psr_next[PSR_C_BIT] = flags.c;
            psr_next[PSR_V_BIT] = flags.v;
        end
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [3:0]        op_i,
    input  logic [WIDTH-1:0]  opa_i,
    input  logic [WIDTH-1:0]  opb_i,
    input  logic              shift_c_i,
    input  logic              carry_i,
    input  logic              set_flags_i,
    input  logic              dst_pc_i,
    input  logic [31:0]       cpsr_i,
    input  logic [31:0]       spsr_i,
    output logic [WIDTH-1:0]  result_o,
    output logic              rd_we_o,
    output logic [31:0]       psr_next_o,
    output logic              restore_o
);

    localparam int unsigned MSB   = WIDTH - 1;
    localparam int unsigned PSR_W = 32;

    alu_op_e          op;
    logic             cls_cmp;
    logic             cls_bit;
    logic [WIDTH-1:0] log_res;
    logic [WIDTH-1:0] ari_res;
    logic             ari_c;
    logic             ari_v;
    logic             upd;
    nzcv_t            nf;

    assign op      = alu_op_e'(op_i);
    assign cls_cmp = op_is_compare(op);
    assign cls_bit = op_is_bitwise(op);

    dp_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .op (op),
        .a  (opa_i),
        .b  (opb_i),
        .res(log_res)
    );

    dp_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .op   (op),
        .a    (opa_i),
        .b    (opb_i),
        .cin  (carry_i),
        .res  (ari_res),
        .c_out(ari_c),
        .v_out(ari_v)
    );

    assign result_o  = cls_bit ? log_res : ari_res;
    assign rd_we_o   = ~cls_cmp;
    assign upd       = cls_cmp | set_flags_i;
    assign restore_o = dst_pc_i & upd;

    always_comb begin
        nf.n = result_o[MSB];
        nf.z = (result_o == '0);
        nf.c = cls_bit ? shift_c_i : ari_c;
        nf.v = cls_bit ? cpsr_i[PSR_V_BIT] : ari_v;
    end

    dp_flag_mux #(.PSR_W(PSR_W)) u_flags (
        .update  (upd),
        .restore (restore_o),
        .flags   (nf),
        .cpsr    (cpsr_i),
        .spsr    (spsr_i),
        .psr_next(psr_next_o)
    );

endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
    parameter int unsigned WIDTH = 32
) (
    input logic [3:0]        op_i,
    input logic [WIDTH-1:0]  opa_i,
    input logic [WIDTH-1:0]  opb_i,
    input logic              set_flags_i,
    input logic              dst_pc_i,
    input logic [31:0]       cpsr_i,
    input logic [31:0]       spsr_i,
    input logic [WIDTH-1:0]  result_o,
    input logic              rd_we_o,
    input logic [31:0]       psr_next_o,
    input logic              restore_o
);

    logic is_cmp;
    logic is_bw;
    assign is_cmp = (op_i[3:2] == 2'b10);
    assign is_bw  = (op_i == 4'h0) || (op_i == 4'h1) || (op_i == 4'h8) || (op_i == 4'h9) ||
                    (op_i >= 4'hC);

    always_comb begin
        assert_cmp_no_write_R7: assert (!(is_cmp && rd_we_o))
            else $error("compare code drove a register write");
        assert_other_writes_R7: assert (is_cmp || rd_we_o)
            else $error("non-compare code without write");
        assert_hold_psr_R8: assert (!(!set_flags_i && !is_cmp) || (psr_next_o == cpsr_i && !restore_o))
            else $error("status changed with flag update off");
        assert_restore_R9: assert (!(set_flags_i && dst_pc_i && !is_cmp) || (restore_o && psr_next_o == spsr_i))
            else $error("missing restore on pc destination");
        assert_cmp_restore_R10: assert (!(is_cmp && dst_pc_i) || (restore_o && psr_next_o == spsr_i))
            else $error("compare to pc did not restore");
        assert_low_bits_R11: assert (restore_o || psr_next_o[27:0] == cpsr_i[27:0])
            else $error("status low bits changed");
        assert_zero_flag_R2: assert (restore_o || !(set_flags_i || is_cmp) || (psr_next_o[30] == (result_o == '0)))
            else $error("Z disagrees with result");
        assert_v_kept_R2: assert (restore_o || !is_bw || (psr_next_o[28] == cpsr_i[28]))
            else $error("bitwise op changed V");
        assert_mov_R1: assert (op_i != 4'hD || result_o == opb_i)
            else $error("MOV result mismatch");
        assert_and_R1: assert (op_i != 4'h0 || result_o == (opa_i & opb_i))
            else $error("AND result mismatch");
    end

endmodule

bind dp_alu dp_alu_checker #(.WIDTH(WIDTH)) u_chk (
    .op_i       (op_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .set_flags_i(set_flags_i),
    .dst_pc_i   (dst_pc_i),
    .cpsr_i     (cpsr_i),
    .spsr_i     (spsr_i),
    .result_o   (result_o),
    .rd_we_o    (rd_we_o),
    .psr_next_o (psr_next_o),
    .restore_o  (restore_o)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;

    typedef struct {
        string       tag;
        logic [31:0] res;
        logic        we;
        logic [31:0] psr;
        logic        rst;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        shift_c_i = 1'b0;
    logic        carry_i = 1'b0;
    logic        set_flags_i = 1'b0;
    logic        dst_pc_i = 1'b0;
    logic [31:0] cpsr_i = '0;
    logic [31:0] spsr_i = '0;
    logic [31:0] result_o;
    logic        rd_we_o;
    logic [31:0] psr_next_o;
    logic        restore_o;

    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    dp_alu u_dut (
        .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .shift_c_i(shift_c_i),
        .carry_i(carry_i), .set_flags_i(set_flags_i), .dst_pc_i(dst_pc_i),
        .cpsr_i(cpsr_i), .spsr_i(spsr_i), .result_o(result_o), .rd_we_o(rd_we_o),
        .psr_next_o(psr_next_o), .restore_o(restore_o)
    );

    function automatic bit s_ovf(input longint s);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    function automatic longint sx(input logic [31:0] x);
        return longint'($signed(x));
    endfunction

    // Reference model written from the requirements
    function automatic exp_t model(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                   logic sc, logic ci, logic s, logic pc,
                                   logic [31:0] cp, logic [31:0] sp);
        exp_t   e;
        logic [31:0] r;
        logic   c, v, bw, cmpop;
        longint x, y, k, w;
        logic [31:0] m, n;
        bw = 1'b0; c = 1'b0; v = 1'b0; r = '0;
        m = a; n = b;
        case (op)
            4'h0, 4'h8: begin r = a & b; bw = 1'b1; end
            4'h1, 4'h9: begin r = a ^ b; bw = 1'b1; end
            4'hC: begin r = a | b; bw = 1'b1; end
            4'hD: begin r = b; bw = 1'b1; end
            4'hE: begin r = a & ~b; bw = 1'b1; end
            4'hF: begin r = ~b; bw = 1'b1; end
            default: ;
        endcase
        if (!bw) begin
            if (op == 4'h3 || op == 4'h7) begin m = b; n = a; end
            x = longint'(m); y = longint'(n);
            if (op == 4'h4 || op == 4'h5 || op == 4'hB) begin
                k = (op == 4'h5) ? longint'(ci) : 0;
                w = x + y + k;
                r = w[31:0];
                c = (w > 64'sd4294967295);
                v = s_ovf(sx(m) + sx(n) + k);
            end else begin
                k = (op == 4'h6 || op == 4'h7) ? longint'(!ci) : 0;
                w = x - y - k;
                r = w[31:0];
                c = (x >= y + k);
                v = s_ovf(sx(m) - sx(n) - k);
            end
        end else begin
            c = sc; v = cp[28];
        end
        cmpop = (op >= 4'h8 && op <= 4'hB);
        e.tag = tag;
        e.res = r;
        e.we  = !cmpop;
        e.rst = pc && (cmpop || s);
        if (e.rst)           e.psr = sp;
        else if (cmpop || s) e.psr = {r[31], (r == 32'h0), c, v, cp[27:0]};
        else                 e.psr = cp;
        return e;
    endfunction

    task automatic drive(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                         logic sc, logic ci, logic s, logic pc,
                         logic [31:0] cp, logic [31:0] sp);
        @(posedge clk);
        #1;
        op_i = op; opa_i = a; opb_i = b; shift_c_i = sc; carry_i = ci;
        set_flags_i = s; dst_pc_i = pc; cpsr_i = cp; spsr_i = sp;
        sb.push_back(model(tag, op, a, b, sc, ci, s, pc, cp, sp));
    endtask

    // Monitor: pop and compare at the falling edge
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (result_o !== e.res || rd_we_o !== e.we || psr_next_o !== e.psr || restore_o !== e.rst) begin
                errors++;
                $display("FAIL %s: actual res=%h we=%b psr=%h rst=%b expected res=%h we=%b psr=%h rst=%b",
                         e.tag, result_o, rd_we_o, psr_next_o, restore_o,
                         e.res, e.we, e.psr, e.rst);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle inputs: R8 (nothing set, AND of zeros)
        drive("R8 idle", 4'h0, 32'h0, 32'h0, 0, 0, 0, 0, 32'h0, 32'h0);
        // R1 bitwise results
        drive("R1 AND", 4'h0, 32'hF0F0_1234, 32'hFF00_FF00, 0, 0, 0, 0, 32'h0000_001F, 32'h0);
        drive("R1 EOR", 4'h1, 32'hAAAA_5555, 32'hFFFF_0000, 0, 0, 0, 0, 32'h0000_0010, 32'h0);
        drive("R1 BIC", 4'hE, 32'hFFFF_FFFF, 32'h0000_FF0F, 0, 0, 0, 0, 32'h0, 32'h0);
        drive("R1 MVN", 4'hF, 32'h0, 32'h1234_5678, 0, 0, 0, 0, 32'h0, 32'h0);
        // R2 bitwise flags: C from shifter, V kept
        drive("R2 ORR flags", 4'hC, 32'h8000_0000, 32'h1, 1, 0, 1, 0, 32'h1000_00D3, 32'h0);
        drive("R2 MOV zero", 4'hD, 32'h5, 32'h0, 0, 1, 1, 0, 32'hF000_0010, 32'h0);
        // R3 subtraction
        drive("R3 SUB equal", 4'h2, 32'h7, 32'h7, 0, 0, 1, 0, 32'h0000_0010, 32'h0);
        drive("R3 SUB borrow", 4'h2, 32'h3, 32'h5, 1, 1, 1, 0, 32'h0000_0010, 32'h0);
        drive("R3 SUB ovf", 4'h2, 32'h8000_0000, 32'h1, 0, 0, 1, 0, 32'h0, 32'h0);
        drive("R3 RSB", 4'h3, 32'h10, 32'h4, 0, 0, 1, 0, 32'h0, 32'h0);
        // R4 addition
        drive("R4 ADD carry", 4'h4, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, 0, 32'h0, 32'h0);
        drive("R4 ADD ovf", 4'h4, 32'h7FFF_FFFF, 32'h1, 0, 0, 1, 0, 32'h0, 32'h0);
        drive("R4 CMN", 4'hB, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 32'h0, 32'h0);
        // R5 carry-in wrap
        drive("R5 ADC cin wrap", 4'h5, 32'hFFFF_FFFF, 32'h0, 0, 1, 1, 0, 32'h0, 32'h0);
        drive("R5 ADC plain", 4'h5, 32'h2, 32'h3, 0, 1, 1, 0, 32'h0, 32'h0);
        // R6 subtract with carry
        drive("R6 SBC wide", 4'h6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 0, 32'h0, 32'h0);
        drive("R6 SBC cset", 4'h6, 32'h9, 32'h4, 0, 1, 1, 0, 32'h0, 32'h0);
        drive("R6 RSC", 4'h7, 32'h4, 32'h4, 0, 0, 1, 0, 32'h0, 32'h0);
        // R7 compares update flags without S, never write
        drive("R7 CMP no S", 4'hA, 32'h5, 32'h5, 0, 0, 0, 0, 32'h0000_00D3, 32'h0);
        drive("R7 TST", 4'h8, 32'hF0, 32'h0F, 1, 0, 0, 0, 32'h1000_0000, 32'h0);
        drive("R7 TEQ", 4'h9, 32'h8000_0001, 32'h1, 0, 0, 1, 0, 32'h0, 32'h0);
        // R8 no flag update
        drive("R8 SUB no S", 4'h2, 32'h0, 32'h1, 1, 1, 0, 0, 32'h5000_0013, 32'hF000_001F);
        // R9 restore on pc destination
        drive("R9 MOV pc S", 4'hD, 32'h0, 32'h0000_0100, 0, 0, 1, 1, 32'h0000_0012, 32'hA000_0030);
        drive("R9 ADD pc S", 4'h4, 32'h8, 32'h4, 0, 0, 1, 1, 32'h0000_0012, 32'h6000_001F);
        drive("R8 ADD pc no S", 4'h4, 32'h8, 32'h4, 0, 0, 0, 1, 32'h3000_0012, 32'h6000_001F);
        // R10 compare with pc destination
        drive("R10 CMP pc", 4'hA, 32'h1, 32'h2, 0, 0, 0, 1, 32'h0000_0011, 32'h9000_0010);
        drive("R10 TST pc S", 4'h8, 32'h0, 32'h0, 1, 0, 1, 1, 32'h0000_0011, 32'h4000_0013);
        // R11 low bits carried through on update
        drive("R11 low bits", 4'h1, 32'h1, 32'h1, 1, 0, 1, 0, 32'h0ABC_DEF3, 32'h0);
        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule